// File: doc/BRIEF.md
# Four-Lane Data Block Writer

This block sends one data block to a card over a 4-bit data bus and then follows the card's answer until the card is ready again. A byte source feeds it through a valid/ready handshake. The writer frames the bytes with a start nibble and an end nibble, and it appends a separate 16-bit CRC for each of the four lanes. Each lane's CRC register is updated in parallel with every nibble that goes out.

After the end nibble the writer releases the bus. It then watches the low data line for the card's status token and records the token bits. It reports busy while the card holds that line low. A programmable cycle limit ends either wait if the card stops answering. A one-cycle done strobe marks the end of every block, whether the block ends normally or by timeout.

Top module: `sdw_block_writer`

## Requirements
- R1: After reset, `dat_oe`, `busy`, `done`, `timeout` and `byte_ready` are low, and `ack_bits` is zero.
- R2: A block is driven with `dat_oe` high for exactly 2·N+18 consecutive cycles. These are one nibble 0x0, 2·N data nibbles, 16 CRC nibbles and one nibble 0xF, where N is `blk_len` and the value 0 means 512 bytes.
- R3: Each byte goes out high nibble first, and nibble bit k appears on `dat_out[k]`.
- R4: In CRC nibble j (j = 0..15), `dat_out[k]` carries bit 15−j of lane k's CRC. Lane k's CRC is the CRC-16 with polynomial x^16+x^12+x^5+1 (0x1021) over that lane's data bits in send order, starting from zero for every block.
- R5: The first byte is taken while the bus is still released, in the cycle before the start nibble. Each later byte is requested in the cycle that drives the previous byte's low nibble. `byte_ready` is high for exactly N cycles when the source is always valid.
- R6: If `byte_valid` is low when a later byte is requested, that slot is sent as 0x00 and still counts toward N.
- R7: After the end nibble, `dat_oe` falls. The writer waits for `dat0_in` to be sampled low (the token start bit) and then shifts the next 4 samples into `ack_bits`, with the first sample ending up in the MSB.
- R8: Right after the token, `busy` is high in every cycle until `dat0_in` is sampled high. `done` is a single-cycle pulse in the cycle after that sample.
- R9: If the token start wait or the busy wait lasts `tmo_limit` cycles without the awaited level, `timeout` is set and `done` pulses. `timeout` and `ack_bits` hold their values until the next accepted `go`, which clears them.
- R10: `go` is ignored while a block or its response is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one nibble per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe, accepted only when idle |
| blk_len | input | 10 | Block length in bytes, 0 = 512 |
| tmo_limit | input | 16 | Cycle limit for each wait |
| byte_data | input | 8 | Byte from the source |
| byte_valid | input | 1 | Source has a byte |
| byte_ready | output | 1 | Writer requests a byte |
| dat0_in | input | 1 | Sampled low data line |
| dat_out | output | 4 | Nibble driven on the data bus |
| dat_oe | output | 1 | Data bus output enable |
| ack_bits | output | 4 | Captured status token bits |
| busy | output | 1 | Card holds the line low after the token |
| timeout | output | 1 | A wait exceeded `tmo_limit` |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
After `go` is sampled, the byte is taken one cycle later and the start nibble follows one cycle after that. The whole frame then runs without gaps. The bench compares every nibble in the cycle in which it is driven. It counts the cycles after `dat_oe` falls, and this count drives the card model's `dat0_in` schedule. From that count it predicts the cycle of `done`. Without a timeout, `done` comes at gap+6+busy_len and `busy` is high busy_len+1 cycles. A timeout while waiting for the token gives `done` at `tmo_limit`. A timeout while busy gives `done` at gap+5+`tmo_limit`. All outputs are sampled on the falling edge, and each prediction is checked against that exact cycle and no other.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int LANES = 4;
  localparam int CRCW = 16;
  localparam logic [CRCW-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [3:0] {
    TX_IDLE, TX_LOAD, TX_START, TX_HI, TX_LO, TX_CRC, TX_END, TX_RESP
  } tx_st_t;

  typedef enum logic [1:0] {
    RM_IDLE, RM_WAIT, RM_CAP, RM_BUSY
  } rm_st_t;

  // One serial CRC step: shift in one data bit, MSB-first register.
  function automatic logic [CRCW-1:0] crc16_step(input logic [CRCW-1:0] c,
                                                 input logic b);
    logic fb;
    fb = b ^ c[CRCW-1];
    return {c[CRCW-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sdw_lane_crc.sv
module sdw_lane_crc
  import sdw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic shift,
  input  logic din,
  output logic msb
);
  logic [CRCW-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clr)   crc_q <= '0;
    else if (upd)   crc_q <= crc16_step(crc_q, din);
    else if (shift) crc_q <= {crc_q[CRCW-2:0], 1'b0};
  end

  assign msb = crc_q[CRCW-1];
endmodule

// File: rtl/sdw_resp_mon.sv
module sdw_resp_mon
  import sdw_pkg::*;
#(
  parameter int ACKW = 4,
  parameter int TMOW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            arm,
  input  logic            dat0_in,
  input  logic [TMOW-1:0] tmo_limit,
  output logic [ACKW-1:0] ack_bits,
  output logic            busy,
  output logic            timeout,
  output logic            fin
);
  localparam int CW = $clog2(ACKW) + 1;

  rm_st_t          m_q;
  logic [TMOW-1:0] tcnt_q;
  logic [CW-1:0]   capn_q;
  logic            tmo_hit;
  logic            expire;

  assign tmo_hit = (tcnt_q == tmo_limit - 1'b1);
  assign expire  = ((m_q == RM_WAIT) && dat0_in && tmo_hit) ||
                   ((m_q == RM_BUSY) && !dat0_in && tmo_hit);
  assign fin     = ((m_q == RM_BUSY) && dat0_in) || expire;
  assign busy    = (m_q == RM_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q      <= RM_IDLE;
      tcnt_q   <= '0;
      capn_q   <= '0;
      ack_bits <= '0;
      timeout  <= 1'b0;
    end else begin
      if (clr) begin
        ack_bits <= '0;
        timeout  <= 1'b0;
      end
      case (m_q)
        RM_IDLE: if (arm) begin
          m_q    <= RM_WAIT;
          tcnt_q <= '0;
        end
        RM_WAIT: begin
          if (!dat0_in) begin
            m_q    <= RM_CAP;
            capn_q <= '0;
          end else if (expire) begin
            timeout <= 1'b1;
            m_q     <= RM_IDLE;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        RM_CAP: begin
          ack_bits <= {ack_bits[ACKW-2:0], dat0_in};
          if (capn_q == CW'(ACKW - 1)) begin
            m_q    <= RM_BUSY;
            tcnt_q <= '0;
          end else capn_q <= capn_q + 1'b1;
        end
        RM_BUSY: begin
          if (dat0_in) m_q <= RM_IDLE;
          else if (expire) begin
            timeout <= 1'b1;
            m_q     <= RM_IDLE;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: m_q <= RM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdw_block_writer.sv
module sdw_block_writer
  import sdw_pkg::*;
#(
  parameter int MAX_BYTES = 512,
  parameter int ACKW = 4,
  parameter int TMOW = 16,
  localparam int LENW = $clog2(MAX_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [LENW-1:0] blk_len,
  input  logic [TMOW-1:0] tmo_limit,
  input  logic [7:0]      byte_data,
  input  logic            byte_valid,
  output logic            byte_ready,
  input  logic            dat0_in,
  output logic [3:0]      dat_out,
  output logic            dat_oe,
  output logic [ACKW-1:0] ack_bits,
  output logic            busy,
  output logic            timeout,
  output logic            done
);
  localparam int CCW = $clog2(CRCW);

  tx_st_t          st_q;
  logic [7:0]      hold_q;
  logic [LENW-1:0] rem_q;
  logic [CCW-1:0]  ccnt_q;
  logic            done_q;

  // Named internal events, also used by the checker.
  logic            go_acc;
  logic            take;
  logic            fin;
  logic            arm;
  logic            nib_upd;
  logic [3:0]      cur_nib;
  logic [LANES-1:0] lane_msb;
  logic [LENW-1:0] len_eff;

  assign go_acc  = (st_q == TX_IDLE) && go;
  assign len_eff = (blk_len == '0) ? LENW'(MAX_BYTES) : blk_len;
  assign byte_ready = (st_q == TX_LOAD) || ((st_q == TX_LO) && (rem_q != '0));
  assign take    = byte_ready && byte_valid;
  assign arm     = (st_q == TX_END);
  assign nib_upd = (st_q == TX_HI) || (st_q == TX_LO);
  assign cur_nib = (st_q == TX_HI) ? hold_q[7:4] : hold_q[3:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sdw_lane_crc u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (go_acc),
      .upd  (nib_upd),
      .shift(st_q == TX_CRC),
      .din  (cur_nib[k]),
      .msb  (lane_msb[k])
    );
  end

  sdw_resp_mon #(.ACKW(ACKW), .TMOW(TMOW)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (go_acc),
    .arm      (arm),
    .dat0_in  (dat0_in),
    .tmo_limit(tmo_limit),
    .ack_bits (ack_bits),
    .busy     (busy),
    .timeout  (timeout),
    .fin      (fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      hold_q <= '0;
      rem_q  <= '0;
      ccnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      case (st_q)
        TX_IDLE: if (go) begin
          st_q  <= TX_LOAD;
          rem_q <= len_eff;
        end
        TX_LOAD: if (byte_valid) begin
          hold_q <= byte_data;
          rem_q  <= rem_q - 1'b1;
          st_q   <= TX_START;
        end
        TX_START: st_q <= TX_HI;
        TX_HI:    st_q <= TX_LO;
        TX_LO: begin
          if (rem_q != '0) begin
            hold_q <= byte_valid ? byte_data : 8'h00;
            rem_q  <= rem_q - 1'b1;
            st_q   <= TX_HI;
          end else begin
            ccnt_q <= '0;
            st_q   <= TX_CRC;
          end
        end
        TX_CRC: begin
          ccnt_q <= ccnt_q + 1'b1;
          if (ccnt_q == CCW'(CRCW - 1)) st_q <= TX_END;
        end
        TX_END:  st_q <= TX_RESP;
        TX_RESP: if (fin) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      TX_START: dat_out = 4'h0;
      TX_HI,
      TX_LO:    dat_out = cur_nib;
      TX_CRC:   dat_out = lane_msb;
      default:  dat_out = 4'hF;
    endcase
  end

  assign dat_oe = (st_q == TX_START) || nib_upd || (st_q == TX_CRC) || (st_q == TX_END);
  assign done   = done_q;
endmodule

// File: rtl/sdw_chk.sv
module sdw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dat_oe,
  input logic [3:0] dat_out,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic       take,
  input logic       fin
);
  // R2
  start_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> dat_out == 4'h0);
  // R2
  end_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe) |-> $past(dat_out) == 4'hF);
  // R5
  first_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !dat_oe) |=> (dat_oe && dat_out == 4'h0));
  // R8
  busy_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dat_oe);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R8
  fin_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done);
  // R9
  tmo_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
endmodule

bind sdw_block_writer sdw_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dat_oe (dat_oe),
  .dat_out(dat_out),
  .busy   (busy),
  .done   (done),
  .timeout(timeout),
  .take   (take),
  .fin    (fin)
);

// File: tb/sim_sdw_block_writer.sv
module sim_sdw_block_writer;
  localparam int ACKW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [9:0]  blk_len = '0;
  logic [15:0] tmo_limit = 16'd10;
  logic [7:0]  byte_data;
  logic        byte_valid;
  logic        byte_ready;
  logic        dat0_in = 1'b1;
  logic [3:0]  dat_out;
  logic        dat_oe;
  logic [3:0]  ack_bits;
  logic        busy, timeout, done;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // byte source
  int cur_seed = 0;
  int cur_skip = -1;
  int src_idx = 0;
  bit skipped = 0;
  bit src_clr = 0;

  logic [7:0] eb [0:511];
  logic [3:0] ex [0:1100];

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int k, int seed);
    if (seed == 100) return 8'hFF;
    if (seed == 101) return 8'h00;
    return 8'((k * 37 + seed * 53 + (k >> 3) + 5) & 255);
  endfunction

  assign byte_data  = pat(src_idx, cur_seed);
  assign byte_valid = !(cur_skip >= 0 && src_idx == cur_skip && !skipped);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_clr) begin
      src_idx <= 0;
      skipped <= 0;
    end else begin
      if (byte_ready && byte_valid) src_idx <= src_idx + 1;
      if (byte_ready && !byte_valid) skipped <= 1;
    end
  end

  always @(posedge clk) begin
    if (cyc == 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  sdw_block_writer u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .blk_len(blk_len), .tmo_limit(tmo_limit),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .dat0_in(dat0_in), .dat_out(dat_out), .dat_oe(dat_oe), .ack_bits(ack_bits),
    .busy(busy), .timeout(timeout), .done(done)
  );

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // CRC by long division of the lane message augmented with 16 zeros.
  function automatic logic [15:0] lane_crc(int n, int lane);
    logic [16:0] w;
    logic b;
    w = '0;
    for (int i = 0; i < 2 * n + 16; i++) begin
      if (i < 2 * n) b = (i % 2 == 0) ? eb[i/2][4+lane] : eb[i/2][lane];
      else b = 1'b0;
      w = {w[15:0], b};
      if (w[16]) w = w ^ 17'h11021;
    end
    return w[15:0];
  endfunction

  task automatic run(int len, int seed, int skip, int gap, logic [3:0] tok,
                     int nbusy, int tmo, bit goag);
    int n, nexp, s, dpost, ebusy, pos, post, rdy, busyc;
    bit eto, fin;
    logic [3:0] eack;
    logic [15:0] cr [0:3];
    logic d;
    n = (len == 0) ? 512 : len;
    for (int k = 0; k < n; k++) begin
      if (skip < 0 || k < skip) eb[k] = pat(k, seed);
      else if (k == skip) eb[k] = 8'h00;
      else eb[k] = pat(k - 1, seed);
    end
    for (int l = 0; l < 4; l++) cr[l] = lane_crc(n, l);
    nexp = 2 * n + 18;
    ex[0] = 4'h0;
    for (int k = 0; k < n; k++) begin
      ex[1 + 2*k] = eb[k][7:4];
      ex[2 + 2*k] = eb[k][3:0];
    end
    for (int j = 0; j < 16; j++)
      for (int l = 0; l < 4; l++) ex[1 + 2*n + j][l] = cr[l][15-j];
    ex[nexp-1] = 4'hF;
    s = gap + 1 + ACKW;
    if (gap >= tmo) begin
      dpost = tmo; eto = 1; eack = 4'h0; ebusy = 0;
    end else if (nbusy >= tmo) begin
      dpost = s + tmo; eto = 1; eack = tok; ebusy = tmo;
    end else begin
      dpost = s + nbusy + 1; eto = 0; eack = tok; ebusy = nbusy + 1;
    end

    @(negedge clk);
    cur_seed = seed; cur_skip = skip; src_clr = 1;
    blk_len = 10'(len); tmo_limit = 16'(tmo); dat0_in = 1'b1;
    @(negedge clk);
    src_clr = 0;
    go = 1;
    @(negedge clk);
    go = 0;
    // R9: flags cleared by an accepted go
    chk(timeout == 1'b0 && ack_bits == 4'h0, "R9 flags cleared on go", {timeout, ack_bits}, 0);
    pos = 0; post = 0; rdy = 0; busyc = 0; fin = 0;
    for (int it = 0; it < 5000 + tmo && !fin; it++) begin
      if (byte_ready) rdy++;
      if (dat_oe) begin
        if (pos >= nexp) chk(0, "R2 frame too long", pos, nexp);
        else if (pos == 0) chk(dat_out == ex[pos], "R2 start nibble", dat_out, ex[pos]);
        else if (pos == nexp - 1) chk(dat_out == ex[pos], "R2 end nibble", dat_out, ex[pos]);
        else if (pos <= 2 * n) chk(dat_out == ex[pos], "R3/R6 data nibble", dat_out, ex[pos]);
        else chk(dat_out == ex[pos], "R4 lane crc nibble", dat_out, ex[pos]);
        pos++;
      end else if (pos > 0) begin
        if (busy) busyc++;
        if (done) begin
          fin = 1;
          chk(post == dpost, "R8 done cycle", post, dpost);
        end
        if (post < gap) d = 1'b1;
        else if (post == gap) d = 1'b0;
        else if (post <= gap + ACKW) d = tok[ACKW - 1 - (post - gap - 1)];
        else if (post < s + nbusy) d = 1'b0;
        else d = 1'b1;
        dat0_in = d;
        post++;
      end
      // R10: a go pulse in mid-response must be ignored
      go = goag && (post == 3);
      if (!fin) @(negedge clk);
    end
    go = 0;
    dat0_in = 1'b1;
    chk(fin, "R8 done seen", fin, 1);
    chk(pos == nexp, "R2 frame length", pos, nexp);
    chk(rdy == n, "R5 byte requests", rdy, n);
    chk(ack_bits == eack, "R7 token bits", ack_bits, eack);
    chk(timeout == eto, "R9 timeout flag", timeout, eto);
    chk(busyc == ebusy, "R8 busy cycles", busyc, ebusy);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!dat_oe && !done && !busy, "R10 stays idle after done", {dat_oe, done, busy}, 0);
      chk(timeout == eto && ack_bits == eack, "R9 flags held", {timeout, ack_bits}, {eto, eack});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!dat_oe && !busy && !done && !timeout && !byte_ready && ack_bits == 4'h0,
        "R1 reset state", {dat_oe, busy, done, timeout, byte_ready, ack_bits}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!dat_oe && !byte_ready, "R1 idle after reset", {dat_oe, byte_ready}, 0);

    run(4, 1, -1, 2, 4'b0101, 6, 100, 0);
    // near-exhaustive sweep: lengths 1..16 with every token value
    for (int i = 0; i < 16; i++) run(i + 1, i + 3, -1, i % 3, 4'(i), i % 5, 64, 0);
    run(8, 100, -1, 1, 4'b0011, 2, 40, 0);   // all ones
    run(8, 101, -1, 1, 4'b1101, 2, 40, 0);   // all zeros
    run(0, 7, -1, 2, 4'b0101, 3, 100, 0);    // R2: 0 means 512
    run(6, 9, 3, 2, 4'b0101, 3, 100, 0);     // R6: missing byte
    run(3, 4, -1, 1000, 4'b0101, 3, 20, 0);  // R9: no token
    run(3, 5, -1, 1, 4'b0101, 500, 30, 0);   // R9: busy stuck
    run(2, 6, -1, 1, 4'b0101, 9, 10, 0);     // R9 boundary: just in time
    run(2, 6, -1, 1, 4'b0101, 10, 10, 0);    // R9 boundary: expires
    run(2, 8, -1, 4, 4'b0101, 2, 5, 0);      // R9 wait boundary: in time
    run(2, 8, -1, 5, 4'b0101, 2, 5, 0);      // R9 wait boundary: expires
    run(5, 2, -1, 1, 4'b1001, 6, 100, 1);    // R10: go during response

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule